// File: doc/BRIEF.md
# Clock-Stretching I2C Target Interface

This block lets an on-chip host act as a 7-bit-address target on an I2C bus. It runs from the system clock. It brings SCL and SDA in through synchronizers and finds START and STOP conditions and SCL edges. It then shifts in the address byte and compares the seven address bits with `own_addr_i`. On a match it pulls SDA low for the acknowledge clock. It drives both bus lines only as open-drain pull-down enables.

In write direction each received byte goes to a single holding buffer. A full flag and an overflow flag decide whether the next byte is accepted and acknowledged. In read direction the block holds SCL low after every acknowledged byte. The clock is freed only when the host has loaded a byte and pulsed the release input. The byte is then shifted out MSB first, with SDA changing only while SCL is low. An interrupt flag rises at the end of every byte exchanged with this target.

The controller has these states:
- IDLE: waiting for START.
- ADDR: shifting in the address byte.
- ADDR_ACK: driving ACK for a matched address.
- RX_DATA: shifting in a data byte.
- RX_ACK: the acknowledge clock of a received byte.
- TX_STRETCH: holding SCL low.
- TX_LAUNCH: one cycle in which the first bit is set up before SCL is released.
- TX_BITS: shifting a byte out.
- TX_ACK: sampling the controller's acknowledge.
- IGNORE: address mismatch, waiting for START.

The transitions are:
- STOP takes any state to IDLE, and START takes any state to ADDR.
- From ADDR, the eighth SCL fall goes to ADDR_ACK on a match and to IGNORE otherwise.
- From ADDR_ACK, the ninth fall goes to RX_DATA for a write or to TX_STRETCH for a read.
- RX_DATA goes to RX_ACK on its eighth fall, and RX_ACK returns to RX_DATA on the ninth fall.
- TX_STRETCH goes to TX_LAUNCH once the release bit is set, and TX_LAUNCH goes to TX_BITS.
- TX_BITS goes to TX_ACK on its eighth fall.
- From TX_ACK, the ninth fall goes back to TX_STRETCH if the controller acknowledged, or to IDLE if it did not.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset, both pull-down outputs are 0 and full, overflow, read/write and interrupt flags are 0.
- R2: When the first seven bits after START (MSB first) equal `own_addr_i`, SDA is pulled low during the ninth SCL clock, `rx_data_o` takes the whole address byte, and `rw_o` takes its eighth bit (1 = read).
- R3: A mismatched address gets no acknowledge and no interrupt, and all later bytes are left unacknowledged until the next START.
- R4: A data byte completed with full=0 and overflow=0 is moved into `rx_data_o`, acknowledged, and sets full.
- R5: A data byte completed with full=1 and overflow=0 is not acknowledged, leaves `rx_data_o` unchanged and sets overflow.
- R6: A data byte completed while overflow=1 is not acknowledged and leaves `rx_data_o` and full unchanged, whatever full is.
- R7: A pulse on `rx_read_i` clears full, and a pulse on `ovf_clr_i` clears overflow. Neither clears the other flag.
- R8: The interrupt flag is set on the ninth SCL fall of every byte exchanged with this target, including unacknowledged received bytes. It stays set until `irq_clr_i` is pulsed.
- R9: After an acknowledged read address, SCL is held low until the host loads a byte and pulses `release_i`. The byte then appears on SDA MSB first, and SDA changes only while SCL is low.
- R10: When the controller acknowledges a transmitted byte, SCL is held low again until the next release. When it does not acknowledge, SDA is freed and the target waits for a START, ignoring bytes before it.
- R11: A STOP in mid-byte frees both lines and returns the target to waiting for START. A repeated START in mid-byte restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr_i | input | 7 | Address this target answers to |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low_o | output | 1 | Pull SDA low (ACK or data 0) |
| tx_data_i | input | 8 | Byte to transmit |
| tx_load_i | input | 1 | Load `tx_data_i` into the transmit shifter |
| release_i | input | 1 | Set the clock-release bit |
| rx_data_o | output | 8 | Holding buffer contents |
| rx_read_i | input | 1 | Host read of the buffer, clears full |
| full_o | output | 1 | Holding buffer full |
| ovf_o | output | 1 | Overflow flag |
| ovf_clr_i | input | 1 | Clear overflow |
| rw_o | output | 1 | Direction bit of the last matched address |
| irq_o | output | 1 | Byte-complete interrupt flag |
| irq_clr_i | input | 1 | Clear interrupt flag |

## Verification
The bench builds the target with the default two-stage synchronizer. It drives a bus half-period of ten system clocks, so every SCL edge has passed the three-cycle detection path before the next bus event. That margin lets the bench model the controller with plain level changes while still reaching all four full/overflow combinations. It also covers stretches that outlast several half-periods, and aborts in the middle of an address or data byte. Seeded random traffic interleaves host buffer reads and overflow clears between bytes, so accept and reject decisions arise in orders no directed case lists.

// File: rtl/i2c_slv_pkg.sv
`timescale 1ns/1ps
package i2c_slv_pkg;
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned BYTE_W = ADDR_W + 1;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_RX_DATA,
        S_RX_ACK,
        S_TX_STRETCH,
        S_TX_LAUNCH,
        S_TX_BITS,
        S_TX_ACK,
        S_IGNORE
    } slv_state_e;
endpackage

// File: rtl/i2c_slv_sync.sv
`timescale 1ns/1ps
module i2c_slv_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int unsigned LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev_q;

    assign raw = {sda_raw, scl_raw};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= synced;
    end

    assign scl_o      = synced[0];
    assign sda_o      = synced[1];
    assign scl_rise_o = synced[0] & ~prev_q[0];
    assign scl_fall_o = ~synced[0] & prev_q[0];
    // Line changes on SDA while SCL stays high frame a transfer.
    assign start_o    = prev_q[0] & synced[0] & prev_q[1] & ~synced[1];
    assign stop_o     = prev_q[0] & synced[0] & ~prev_q[1] & synced[1];
endmodule

// File: rtl/i2c_slv_core.sv
`timescale 1ns/1ps
module i2c_slv_core
    import i2c_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start,
    input  logic              stop,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_load,
    input  logic              release_set,
    input  logic              rd_buf,
    input  logic              clr_ovf,
    input  logic              clr_irq,
    output logic              scl_low_o,
    output logic              sda_low_o,
    output logic [BYTE_W-1:0] buf_o,
    output logic              full_o,
    output logic              ovf_o,
    output logic              rw_o,
    output logic              irq_o
);
    localparam int unsigned     CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W);

    slv_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sr_q, txsr_q, buf_q;
    logic              full_q, ovf_q, rw_q, irq_q, release_q, nack_q;
    logic              scl_low_q, sda_low_q;
    logic              byte_end, addr_hit;

    assign byte_end = scl_fall && (cnt_q == CNT_LAST);
    assign addr_hit = (sr_q[BYTE_W-1:1] == own_addr);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop) begin
            state_d = S_IDLE;
        end else if (start) begin
            state_d = S_ADDR;
        end else begin
            unique case (state_q)
                S_ADDR:       if (byte_end) state_d = addr_hit ? S_ADDR_ACK : S_IGNORE;
                S_ADDR_ACK:   if (scl_fall) state_d = rw_q ? S_TX_STRETCH : S_RX_DATA;
                S_RX_DATA:    if (byte_end) state_d = S_RX_ACK;
                S_RX_ACK:     if (scl_fall) state_d = S_RX_DATA;
                S_TX_STRETCH: if (release_q) state_d = S_TX_LAUNCH;
                S_TX_LAUNCH:  state_d = S_TX_BITS;
                S_TX_BITS:    if (byte_end) state_d = S_TX_ACK;
                S_TX_ACK:     if (scl_fall) state_d = nack_q ? S_IDLE : S_TX_STRETCH;
                default:      state_d = state_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Datapath, flags and line drives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            sr_q      <= '0;
            txsr_q    <= '0;
            buf_q     <= '0;
            full_q    <= 1'b0;
            ovf_q     <= 1'b0;
            rw_q      <= 1'b0;
            irq_q     <= 1'b0;
            release_q <= 1'b0;
            nack_q    <= 1'b0;
            scl_low_q <= 1'b0;
            sda_low_q <= 1'b0;
        end else begin
            if (tx_load)     txsr_q    <= tx_data;
            if (release_set) release_q <= 1'b1;
            if (rd_buf)      full_q    <= 1'b0;
            if (clr_ovf)     ovf_q     <= 1'b0;
            if (clr_irq)     irq_q     <= 1'b0;

            if (start || stop) begin
                cnt_q     <= '0;
                scl_low_q <= 1'b0;
                sda_low_q <= 1'b0;
                nack_q    <= 1'b0;
            end else begin
                unique case (state_q)
                    S_ADDR, S_RX_DATA: begin
                        if (scl_rise) begin
                            sr_q  <= {sr_q[BYTE_W-2:0], sda_s};
                            cnt_q <= cnt_q + 1'b1;
                        end
                        if (byte_end) begin
                            if (state_q == S_ADDR) begin
                                if (addr_hit) begin
                                    buf_q     <= sr_q;
                                    rw_q      <= sr_q[0];
                                    sda_low_q <= 1'b1;
                                end
                            end else if (!full_q && !ovf_q) begin
                                buf_q     <= sr_q;
                                full_q    <= 1'b1;
                                sda_low_q <= 1'b1;
                            end else if (full_q) begin
                                ovf_q <= 1'b1;
                            end
                        end
                    end
                    S_ADDR_ACK, S_RX_ACK: begin
                        if (scl_fall) begin
                            sda_low_q <= 1'b0;
                            irq_q     <= 1'b1;
                            cnt_q     <= '0;
                            if (state_q == S_ADDR_ACK && rw_q) begin
                                scl_low_q <= 1'b1;
                                release_q <= 1'b0;
                            end
                        end
                    end
                    S_TX_STRETCH: begin
                        if (release_q) begin
                            release_q <= 1'b0;
                            sda_low_q <= ~txsr_q[BYTE_W-1];
                        end
                    end
                    S_TX_LAUNCH: begin
                        scl_low_q <= 1'b0;
                    end
                    S_TX_BITS: begin
                        if (scl_rise) cnt_q <= cnt_q + 1'b1;
                        if (scl_fall) begin
                            if (cnt_q == CNT_LAST) begin
                                sda_low_q <= 1'b0;
                            end else begin
                                txsr_q    <= {txsr_q[BYTE_W-2:0], 1'b0};
                                sda_low_q <= ~txsr_q[BYTE_W-2];
                            end
                        end
                    end
                    S_TX_ACK: begin
                        if (scl_rise) nack_q <= sda_s;
                        if (scl_fall) begin
                            irq_q <= 1'b1;
                            cnt_q <= '0;
                            if (!nack_q) begin
                                scl_low_q <= 1'b1;
                                release_q <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign scl_low_o = scl_low_q;
    assign sda_low_o = sda_low_q;
    assign buf_o     = buf_q;
    assign full_o    = full_q;
    assign ovf_o     = ovf_q;
    assign rw_o      = rw_q;
    assign irq_o     = irq_q;

    // R5: a full buffer is never overwritten by a data byte
    p_hold_buf_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RX_DATA && full_q) |=> $stable(buf_q));

    // R6: overflow only leaves through the host clear
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_ovf) |=> ovf_q);

    // R8: the interrupt flag rises only on an SCL falling edge
    p_irq_at_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(scl_fall));

    // R9: stretch is kept until the release bit is seen
    p_stretch_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_TX_STRETCH && !release_q) |=> scl_low_q);

    // R9: the SDA drive moves only while SCL is low
    p_sda_moves_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_low_q) && !$past(start || stop)) |-> !$past(scl_s));
endmodule

// File: rtl/i2c_stretch_slave.sv
`timescale 1ns/1ps
module i2c_stretch_slave
    import i2c_slv_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low_o,
    output logic              sda_drive_low_o,
    input  logic [BYTE_W-1:0] tx_data_i,
    input  logic              tx_load_i,
    input  logic              release_i,
    output logic [BYTE_W-1:0] rx_data_o,
    input  logic              rx_read_i,
    output logic              full_o,
    output logic              ovf_o,
    input  logic              ovf_clr_i,
    output logic              rw_o,
    output logic              irq_o,
    input  logic              irq_clr_i
);
    logic scl_s, sda_s, scl_rise, scl_fall, start, stop;

    i2c_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_raw    (scl_i),
        .sda_raw    (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start),
        .stop_o     (stop)
    );

    i2c_slv_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .own_addr    (own_addr_i),
        .scl_s       (scl_s),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start       (start),
        .stop        (stop),
        .tx_data     (tx_data_i),
        .tx_load     (tx_load_i),
        .release_set (release_i),
        .rd_buf      (rx_read_i),
        .clr_ovf     (ovf_clr_i),
        .clr_irq     (irq_clr_i),
        .scl_low_o   (scl_drive_low_o),
        .sda_low_o   (sda_drive_low_o),
        .buf_o       (rx_data_o),
        .full_o      (full_o),
        .ovf_o       (ovf_o),
        .rw_o        (rw_o),
        .irq_o       (irq_o)
    );
endmodule

// File: tb/i2c_stretch_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_stretch_slave_tb_top;
    localparam int H = 10;
    localparam logic [6:0] OWN = 7'h5A;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic [7:0] tx_data_i = '0;
    logic       tx_load_i = 1'b0, release_i = 1'b0, rx_read_i = 1'b0;
    logic       ovf_clr_i = 1'b0, irq_clr_i = 1'b0;
    logic       scl_drive_low_o, sda_drive_low_o, full_o, ovf_o, rw_o, irq_o;
    logic [7:0] rx_data_o;
    logic       scl_w, sda_w;

    assign scl_w = ~(m_scl_low | scl_drive_low_o);
    assign sda_w = ~(m_sda_low | sda_drive_low_o);

    i2c_stretch_slave dut_i (
        .clk(clk), .rst_n(rst_n), .own_addr_i(OWN),
        .scl_i(scl_w), .sda_i(sda_w),
        .scl_drive_low_o(scl_drive_low_o), .sda_drive_low_o(sda_drive_low_o),
        .tx_data_i(tx_data_i), .tx_load_i(tx_load_i), .release_i(release_i),
        .rx_data_o(rx_data_o), .rx_read_i(rx_read_i),
        .full_o(full_o), .ovf_o(ovf_o), .ovf_clr_i(ovf_clr_i),
        .rw_o(rw_o), .irq_o(irq_o), .irq_clr_i(irq_clr_i)
    );

    int n_chk = 0;
    int n_err = 0;
    logic       m_full = 1'b0, m_ovf = 1'b0;
    logic [7:0] m_buf = '0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_w) cyc(1);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; cyc(H);
        m_scl_low = 1'b0; wait_scl_high(); cyc(H);
        m_sda_low = 1'b1; cyc(H);
        m_scl_low = 1'b1; cyc(H);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; cyc(H);
        m_scl_low = 1'b0; wait_scl_high(); cyc(H);
        m_sda_low = 1'b0; cyc(H);
    endtask

    task automatic bus_bit(input logic b, output logic got);
        m_sda_low = ~b; cyc(H);
        m_scl_low = 1'b0; wait_scl_high(); cyc(H);
        got = sda_w;
        m_scl_low = 1'b1; cyc(H);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic g;
        for (int i = 7; i >= 0; i--) bus_bit(d[i], g);
        bus_bit(1'b1, g);
        ack = ~g;
    endtask

    task automatic read_byte(input logic m_ack, output logic [7:0] d);
        logic g;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, g);
            d[i] = g;
        end
        bus_bit(~m_ack, g);
    endtask

    task automatic host_rd(output logic [7:0] d);
        d = rx_data_o;
        rx_read_i = 1'b1; cyc(1); rx_read_i = 1'b0; cyc(1);
        m_full = 1'b0;
    endtask

    task automatic host_ovf_clr();
        ovf_clr_i = 1'b1; cyc(1); ovf_clr_i = 1'b0; cyc(1);
        m_ovf = 1'b0;
    endtask

    task automatic host_irq_clr();
        irq_clr_i = 1'b1; cyc(1); irq_clr_i = 1'b0; cyc(1);
    endtask

    task automatic host_tx(input logic [7:0] v);
        tx_data_i = v; tx_load_i = 1'b1; cyc(1); tx_load_i = 1'b0;
        release_i = 1'b1; cyc(1); release_i = 1'b0;
    endtask

    function automatic logic exp_accept(input logic f, input logic o);
        return !f && !o;
    endfunction

    // Sends one data byte and checks the outcome against the flag model.
    task automatic wr_data_checked(input logic [7:0] d, input string tag);
        logic ack, acc;
        acc = exp_accept(m_full, m_ovf);
        write_byte(d, ack);
        if (acc) begin
            m_buf = d; m_full = 1'b1;
        end else if (m_full) begin
            m_ovf = 1'b1;
        end
        chk({tag, " ack"}, int'(ack), int'(acc));
        chk({tag, " buffer"}, int'(rx_data_o), int'(m_buf));
        chk({tag, " full"}, int'(full_o), int'(m_full));
        chk({tag, " ovf"}, int'(ovf_o), int'(m_ovf));
        chk("R8 irq after byte", int'(irq_o), 1);
        host_irq_clr();
    endtask

    // Read-direction byte with stretch check first.
    task automatic rd_data_checked(input logic [7:0] v, input logic m_ack, input string tag);
        logic [7:0] d;
        m_scl_low = 1'b0; cyc(3 * H);
        chk({tag, " stretch holds SCL"}, int'(scl_w), 0);
        host_tx(v);
        read_byte(m_ack, d);
        chk({tag, " data"}, int'(d), int'(v));
        chk("R8 irq after tx byte", int'(irq_o), 1);
        host_irq_clr();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        void'($urandom(32'd1357));
        cyc(4); rst_n = 1'b1; cyc(4);

        // R1 reset state
        chk("R1 scl drive", int'(scl_drive_low_o), 0);
        chk("R1 sda drive", int'(sda_drive_low_o), 0);
        chk("R1 full", int'(full_o), 0);
        chk("R1 ovf", int'(ovf_o), 0);
        chk("R1 rw", int'(rw_o), 0);
        chk("R1 irq", int'(irq_o), 0);

        // R2 write address, R4/R5/R6/R7 status table
        bus_start();
        write_byte({OWN, 1'b0}, ack);
        chk("R2 address ack", int'(ack), 1);
        chk("R2 address in buffer", int'(rx_data_o), int'({OWN, 1'b0}));
        chk("R2 rw copy", int'(rw_o), 0);
        chk("R8 irq on address", int'(irq_o), 1);
        host_irq_clr();
        chk("R8 irq cleared", int'(irq_o), 0);
        m_buf = {OWN, 1'b0};
        wr_data_checked(8'hC3, "R4 accept");
        wr_data_checked(8'h11, "R5 full reject");
        host_rd(d);
        chk("R7 read data", int'(d), 8'hC3);
        chk("R7 full cleared", int'(full_o), 0);
        chk("R7 ovf kept", int'(ovf_o), 1);
        wr_data_checked(8'h22, "R6 ovf reject");
        host_ovf_clr();
        chk("R7 ovf cleared", int'(ovf_o), 0);
        wr_data_checked(8'h33, "R4 accept after clear");
        bus_stop();
        host_rd(d);

        // R3 mismatch
        bus_start();
        write_byte({7'h12, 1'b0}, ack);
        chk("R3 no ack on mismatch", int'(ack), 0);
        chk("R3 no irq on mismatch", int'(irq_o), 0);
        write_byte(8'h55, ack);
        chk("R3 later byte ignored", int'(ack), 0);
        chk("R3 full untouched", int'(full_o), 0);
        bus_stop();

        // R9/R10 read transfer
        bus_start();
        write_byte({OWN, 1'b1}, ack);
        chk("R2 read address ack", int'(ack), 1);
        chk("R2 rw read", int'(rw_o), 1);
        host_irq_clr();
        rd_data_checked(8'hA5, 1'b1, "R9 first");
        rd_data_checked(8'h3C, 1'b0, "R10 after ack");
        chk("R10 sda free after nack", int'(sda_drive_low_o), 0);
        chk("R10 scl free after nack", int'(scl_drive_low_o), 0);
        write_byte({OWN, 1'b0}, ack);
        chk("R10 idle ignores bytes", int'(ack), 0);
        bus_stop();

        // R11 STOP mid-byte
        bus_start();
        write_byte({OWN, 1'b0}, ack);
        host_irq_clr();
        for (int i = 0; i < 3; i++) bus_bit(1'b0, ack);
        bus_stop();
        chk("R11 lines free after stop", int'(sda_drive_low_o | scl_drive_low_o), 0);
        write_byte(8'h00, ack);
        chk("R11 idle after stop", int'(ack), 0);
        bus_stop();

        // R11 repeated START mid-byte
        bus_start();
        write_byte({OWN, 1'b0}, ack);
        host_irq_clr();
        for (int i = 0; i < 4; i++) bus_bit(1'b1, ack);
        bus_start();
        write_byte({OWN, 1'b1}, ack);
        chk("R11 restart address ack", int'(ack), 1);
        chk("R11 restart rw", int'(rw_o), 1);
        host_irq_clr();
        rd_data_checked(8'h69, 1'b0, "R11 read after restart");
        bus_stop();

        // Random traffic
        for (int it = 0; it < 20; it++) begin
            int nb;
            nb = 1 + int'($urandom % 4);
            bus_start();
            if ($urandom % 2 == 0) begin
                write_byte({OWN, 1'b0}, ack);
                chk("R2 random address ack", int'(ack), 1);
                m_buf = {OWN, 1'b0};
                host_irq_clr();
                for (int b = 0; b < nb; b++) begin
                    if ($urandom % 2 == 0) begin
                        host_rd(d);
                        chk("R7 random read data", int'(d), int'(m_buf));
                    end
                    if ($urandom % 4 == 0) host_ovf_clr();
                    wr_data_checked(8'($urandom), "R4 random write");
                end
            end else begin
                write_byte({OWN, 1'b1}, ack);
                chk("R2 random read ack", int'(ack), 1);
                host_irq_clr();
                for (int b = 0; b < nb; b++)
                    rd_data_checked(8'($urandom), (b != nb - 1), "R9 random read");
            end
            bus_stop();
        end

        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule